// File: doc/BRIEF.md
# ULPI Link-Side Data Bus Turnaround Controller

This block sits at the link end of an 8-bit bidirectional ULPI-style data bus. Each cycle it decides whether the link may drive the shared data lines, based on the direction signal from the PHY. The aim is that the link and the PHY never drive the lines at the same time. Higher logic gets three things from it: per-bit output data, a per-bit output enable and a registered copy of the bus as the PHY drove it.

The turnaround is asymmetric. When the PHY raises its direction signal, the link releases the bus in the same cycle through a combinational path. The PHY starts driving only from the following edge, so the first cycle with direction high is a turnaround cycle that carries no data. When the PHY lowers direction, the link waits one full cycle with its drivers off and drives again the cycle after.

Two configuration inputs select a serial mode that carries single-ended USB signalling on fixed data bits. A 3-pin variant shares bits 1 and 2 between transmit and receive. A 6-pin variant has separate receive bits 4 to 6.

Top module: `ulpi_link_bus`

## Requirements
- R1: Outside reset, with DIR low in the current and the previous cycle, in parallel mode, the link enables all eight bits. It drives `tx_data` when `tx_valid` is high and all zeros otherwise. This includes the first cycles after reset.
- R2: While `phy_dir` is high, every bit of `bus_oe` is 0 in that same cycle, with no register between `phy_dir` and `bus_oe`. The link's and the PHY's enables are never both high on any bit.
- R3: The first cycle in which `phy_dir` is high is a turnaround cycle, and `rx_valid` stays 0 for it. In parallel mode, each later cycle with DIR high captures `bus_in`, and `rx_data` and `rx_valid=1` appear one clock later.
- R4: In the cycle in which `phy_dir` is first low after being high, `bus_oe` stays all 0. Drive resumes in the next cycle.
- R5: 3-pin mode (`cfg_ser3`=1, `cfg_ser6`=0) puts transmit enable on bit 0, transmit data on bit 1 and transmit SE0 on bit 2. The link enables bits 0 to 2 (`bus_oe`=8'h07) only while `ser_tx_en` is high and drive is allowed. Otherwise `bus_oe` is 8'h00. `bus_out` bits 3 to 7 are always 0.
- R6: In 3-pin mode, while the link is not driving bit 0, `ser_rx_rcv` takes `bus_in[1]` and `ser_rx_se0` takes `bus_in[2]` one clock later. They hold while the link drives.
- R7: 6-pin mode (`cfg_ser6`=1, `cfg_ser3`=0) maps bits 0 to 2 as in R5. These bits are enabled whenever drive is allowed, whatever `ser_tx_en` is, and bits 3 to 7 are never enabled.
- R8: In 6-pin mode, `ser_rx_dp`, `ser_rx_dm` and `ser_rx_rcv` take `bus_in[4]`, `bus_in[5]` and `bus_in[6]` every cycle, one clock later.
- R9: With both configuration inputs high, the bus behaves exactly as in parallel mode.
- R10: In either serial mode `rx_valid` is 0 in the following cycle. All registered outputs reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ser3 | input | 1 | Select 3-pin serial mode |
| cfg_ser6 | input | 1 | Select 6-pin serial mode |
| phy_dir | input | 1 | PHY direction, high when the PHY owns the bus |
| tx_valid | input | 1 | Parallel transmit word present |
| tx_data | input | DATA_W | Parallel transmit word |
| ser_tx_en | input | 1 | Serial transmit enable |
| ser_tx_dat | input | 1 | Serial transmit data |
| ser_tx_se0 | input | 1 | Serial transmit SE0 |
| bus_in | input | DATA_W | Data lines as seen at the pads |
| bus_out | output | DATA_W | Link output value per bit |
| bus_oe | output | DATA_W | Link output enable per bit |
| rx_data | output | DATA_W | Captured PHY word |
| rx_valid | output | 1 | `rx_data` holds a fresh word |
| ser_rx_rcv | output | 1 | Serial differential receive |
| ser_rx_se0 | output | 1 | Serial receive SE0 (3-pin) |
| ser_rx_dp | output | 1 | Serial receive D+ (6-pin) |
| ser_rx_dm | output | 1 | Serial receive D- (6-pin) |

## Verification
The bench models the PHY. The PHY drives every bit only from the second cycle with DIR high onward, bits 1 and 2 in 3-pin mode while the link is released, and bits 4 to 6 in 6-pin mode. Any overlap of enables is flagged as contention.

The bench goes after three turnaround cases:
- Single-cycle DIR pulses. A design that registers the release would collide with the PHY on the cycle after the rise.
- DIR falling and then rising again at once. A design without the one-cycle hold after the fall would drive into the PHY on that first low cycle.
- Bus contents in the turnaround cycle. A design that captured them would report garbage as valid data.

The bench also changes mode while traffic runs. A 3-pin design that ignored transmit enable would block its own receive path. A 6-pin design that drove bits 3 to 7 would fight the PHY on the receive bits.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  typedef enum logic [1:0] {
    BUS_PARALLEL = 2'd0,
    BUS_SER3     = 2'd1,
    BUS_SER6     = 2'd2
  } bus_mode_e;

  // Fixed lane positions used by both serial variants
  localparam int LANE_TXEN  = 0;
  localparam int LANE_TXDAT = 1;
  localparam int LANE_TXSE0 = 2;
  localparam int LANE_RXDP  = 4;
  localparam int LANE_RXDM  = 5;
  localparam int LANE_RXRCV = 6;
  localparam int SER_TX_TOP = 2;

  // Conflicting selections fall back to the parallel bus
  function automatic bus_mode_e decode_mode(input logic sel3, input logic sel6);
    if (sel3 && !sel6) return BUS_SER3;
    if (sel6 && !sel3) return BUS_SER6;
    return BUS_PARALLEL;
  endfunction

  // Whether the link wants lane idx in the given mode
  function automatic logic lane_claim(input bus_mode_e m, input int idx, input logic tx_en);
    case (m)
      BUS_SER6: return (idx <= SER_TX_TOP);
      BUS_SER3: return (idx <= SER_TX_TOP) && tx_en;
      default:  return 1'b1;
    endcase
  endfunction

  // Serial value placed on lane idx
  function automatic logic serial_lane_value(input int idx, input logic en,
                                             input logic dat, input logic se0);
    case (idx)
      LANE_TXEN:  return en;
      LANE_TXDAT: return dat;
      LANE_TXSE0: return se0;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ulpi_turnaround.sv
module ulpi_turnaround (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_dir,
  output logic dir_q,
  output logic drive_ok,
  output logic rx_window,
  output logic turn_in,
  output logic turn_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= phy_dir;
  end

  // Release is immediate on DIR; re-drive waits for the registered copy
  assign drive_ok  = !phy_dir && !dir_q;
  assign rx_window =  phy_dir &&  dir_q;
  assign turn_in   =  phy_dir && !dir_q;
  assign turn_out  = !phy_dir &&  dir_q;

endmodule

// File: rtl/ulpi_drive_mux.sv
module ulpi_drive_mux
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bus_mode_e          mode,
  input  logic               drive_ok,
  input  logic               tx_valid,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               ser_tx_en,
  input  logic               ser_tx_dat,
  input  logic               ser_tx_se0,
  output logic [DATA_W-1:0]  bus_out,
  output logic [DATA_W-1:0]  bus_oe
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    logic claim;
    logic value;
    always_comb begin
      claim = lane_claim(mode, b, ser_tx_en);
      if (mode == BUS_PARALLEL) value = tx_valid && tx_data[b];
      else                      value = serial_lane_value(b, ser_tx_en, ser_tx_dat, ser_tx_se0);
    end
    assign bus_oe[b]  = drive_ok && claim;
    assign bus_out[b] = bus_oe[b] && value;
  end

endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_mode_e          mode,
  input  logic               rx_window,
  input  logic               ser_lines_free,
  input  logic [DATA_W-1:0]  bus_in,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               ser_rx_rcv,
  output logic               ser_rx_se0,
  output logic               ser_rx_dp,
  output logic               ser_rx_dm
);

  logic take_word;
  logic take_ser3;
  logic take_ser6;

  assign take_word = rx_window && (mode == BUS_PARALLEL);
  assign take_ser3 = ser_lines_free && (mode == BUS_SER3);
  assign take_ser6 = (mode == BUS_SER6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= take_word;
      if (take_word) rx_data <= bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_rx_rcv <= 1'b0;
      ser_rx_se0 <= 1'b0;
      ser_rx_dp  <= 1'b0;
      ser_rx_dm  <= 1'b0;
    end else if (take_ser3) begin
      ser_rx_rcv <= bus_in[LANE_TXDAT];
      ser_rx_se0 <= bus_in[LANE_TXSE0];
    end else if (take_ser6) begin
      ser_rx_rcv <= bus_in[LANE_RXRCV];
      ser_rx_dp  <= bus_in[LANE_RXDP];
      ser_rx_dm  <= bus_in[LANE_RXDM];
    end
  end

endmodule

// File: rtl/ulpi_link_bus.sv
module ulpi_link_bus
  import ulpi_link_pkg::*;
#(
  parameter int DATA_W = 8  // at least 8: serial lanes sit at fixed bits
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_ser3,
  input  logic               cfg_ser6,
  input  logic               phy_dir,
  input  logic               tx_valid,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               ser_tx_en,
  input  logic               ser_tx_dat,
  input  logic               ser_tx_se0,
  input  logic [DATA_W-1:0]  bus_in,
  output logic [DATA_W-1:0]  bus_out,
  output logic [DATA_W-1:0]  bus_oe,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               ser_rx_rcv,
  output logic               ser_rx_se0,
  output logic               ser_rx_dp,
  output logic               ser_rx_dm
);

  bus_mode_e mode;
  logic      dir_q;
  logic      drive_ok;
  logic      rx_window;
  logic      turn_in;
  logic      turn_out;
  logic      ser_lines_free;

  assign mode           = decode_mode(cfg_ser3, cfg_ser6);
  assign ser_lines_free = !bus_oe[LANE_TXEN];

  ulpi_turnaround i_turn (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_dir   (phy_dir),
    .dir_q     (dir_q),
    .drive_ok  (drive_ok),
    .rx_window (rx_window),
    .turn_in   (turn_in),
    .turn_out  (turn_out)
  );

  ulpi_drive_mux #(.DATA_W(DATA_W)) i_mux (
    .mode       (mode),
    .drive_ok   (drive_ok),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .ser_tx_en  (ser_tx_en),
    .ser_tx_dat (ser_tx_dat),
    .ser_tx_se0 (ser_tx_se0),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe)
  );

  ulpi_rx_capture #(.DATA_W(DATA_W)) i_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode),
    .rx_window      (rx_window),
    .ser_lines_free (ser_lines_free),
    .bus_in         (bus_in),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .ser_rx_rcv     (ser_rx_rcv),
    .ser_rx_se0     (ser_rx_se0),
    .ser_rx_dp      (ser_rx_dp),
    .ser_rx_dm      (ser_rx_dm)
  );

endmodule

// File: rtl/ulpi_link_bus_chk.sv
module ulpi_link_bus_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ser3,
  input logic              cfg_ser6,
  input logic              phy_dir,
  input logic              tx_valid,
  input logic              ser_tx_en,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] bus_oe,
  input logic              rx_valid,
  input logic              turn_in,
  input logic              turn_out
);

  logic is_par;
  logic is_ser3;
  logic is_ser6;
  assign is_ser3 = cfg_ser3 && !cfg_ser6;
  assign is_ser6 = cfg_ser6 && !cfg_ser3;
  assign is_par  = !is_ser3 && !is_ser6;

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_dir && !$past(phy_dir) && is_par && !tx_valid) |-> (bus_oe == '1 && bus_out == '0));

  assert_dir_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_dir |-> (bus_oe == '0));

  assert_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
    turn_in |=> !rx_valid);

  assert_fall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    turn_out |-> (bus_oe == '0));

  assert_ser3_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ser3 && !ser_tx_en) |-> (bus_oe == '0));

  assert_ser6_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ser6 |-> (bus_oe[DATA_W-1:3] == '0));

  assert_serial_novalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ser3 || is_ser6) |=> !rx_valid);

endmodule

bind ulpi_link_bus ulpi_link_bus_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_ser3  (cfg_ser3),
  .cfg_ser6  (cfg_ser6),
  .phy_dir   (phy_dir),
  .tx_valid  (tx_valid),
  .ser_tx_en (ser_tx_en),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .rx_valid  (rx_valid),
  .turn_in   (turn_in),
  .turn_out  (turn_out)
);

// File: tb/test_ulpi_link_bus.sv
`timescale 1ns/1ps
module test_ulpi_link_bus;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cfg_ser3 = 1'b0, cfg_ser6 = 1'b0, phy_dir = 1'b0;
  logic         tx_valid = 1'b0, ser_tx_en = 1'b0, ser_tx_dat = 1'b0, ser_tx_se0 = 1'b0;
  logic [W-1:0] tx_data = '0, bus_in = '0;
  logic [W-1:0] bus_out, bus_oe, rx_data;
  logic         rx_valid, ser_rx_rcv, ser_rx_se0, ser_rx_dp, ser_rx_dm;

  ulpi_link_bus #(.DATA_W(W)) i_ulpi_link_bus (
    .clk(clk), .rst_n(rst_n), .cfg_ser3(cfg_ser3), .cfg_ser6(cfg_ser6),
    .phy_dir(phy_dir), .tx_valid(tx_valid), .tx_data(tx_data),
    .ser_tx_en(ser_tx_en), .ser_tx_dat(ser_tx_dat), .ser_tx_se0(ser_tx_se0),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .ser_rx_rcv(ser_rx_rcv), .ser_rx_se0(ser_rx_se0),
    .ser_rx_dp(ser_rx_dp), .ser_rx_dm(ser_rx_dm)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic         dir_prev_b = 1'b0;
  logic [W-1:0] e_data = '0;
  logic         e_valid = 1'b0, e_rcv = 1'b0, e_se0 = 1'b0, e_dp = 1'b0, e_dm = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // 0 parallel, 1 three-pin, 2 six-pin
  function automatic int mode_of(input logic s3, input logic s6);
    if (s3 && !s6) return 1;
    if (s6 && !s3) return 2;
    return 0;
  endfunction

  function automatic logic [W-1:0] want_oe(input int m, input logic dir, input logic dprev,
                                           input logic ten);
    if (dir || dprev) return '0;
    if (m == 0) return '1;
    if (m == 2) return 8'h07;
    return ten ? 8'h07 : 8'h00;
  endfunction

  function automatic logic [W-1:0] want_out(input int m, input logic [W-1:0] oe,
                                            input logic txv, input logic [W-1:0] txd,
                                            input logic ten, input logic tdat, input logic tse0);
    logic [W-1:0] v;
    if (m == 0) v = txv ? txd : '0;
    else        v = {5'b0, tse0, tdat, ten};
    return v & oe;
  endfunction

  function automatic logic [W-1:0] phy_mask(input int m, input logic dir, input logic dprev,
                                            input logic [W-1:0] link_oe);
    if (m == 0) return (dir && dprev) ? 8'hFF : 8'h00;
    if (m == 1) return (link_oe == 0) ? 8'h06 : 8'h00;
    return 8'h70;
  endfunction

  task automatic step(input logic dir, input logic s3, input logic s6,
                      input logic txv, input logic [W-1:0] txd,
                      input logic ten, input logic tdat, input logic tse0,
                      input logic [W-1:0] phy_val);
    int m;
    logic [W-1:0] eo, pm;
    string req;
    @(negedge clk);
    dir_prev_b = phy_dir;
    phy_dir = dir; cfg_ser3 = s3; cfg_ser6 = s6;
    tx_valid = txv; tx_data = txd;
    ser_tx_en = ten; ser_tx_dat = tdat; ser_tx_se0 = tse0;
    m  = mode_of(s3, s6);
    eo = want_oe(m, dir, dir_prev_b, ten);
    pm = phy_mask(m, dir, dir_prev_b, eo);
    #0.5;
    bus_in = (bus_out & bus_oe) | (phy_val & pm & ~bus_oe);
    #0.5;
    // combinational drive
    if (dir)                req = "R2";
    else if (dir_prev_b)    req = "R4";
    else if (m == 1)        req = "R5";
    else if (m == 2)        req = "R7";
    else if (s3 && s6)      req = "R9";
    else                    req = "R1";
    check(req, "bus_oe", 32'(bus_oe), 32'(eo));
    check(req, "bus_out", 32'(bus_out), 32'(want_out(m, eo, txv, txd, ten, tdat, tse0)));
    check("R2", "contention", 32'(bus_oe & pm), 32'h0);
    // registered outputs from last edge
    check((m == 0) ? "R3" : "R10", "rx_valid", 32'(rx_valid), 32'(e_valid));
    check("R3", "rx_data", 32'(rx_data), 32'(e_data));
    check("R6", "ser_rx_rcv/se0", {30'b0, ser_rx_rcv, ser_rx_se0}, {30'b0, e_rcv, e_se0});
    check("R8", "ser_rx_dp/dm", {30'b0, ser_rx_dp, ser_rx_dm}, {30'b0, e_dp, e_dm});
    // next expected register state
    e_valid = dir && dir_prev_b && (m == 0);
    if (e_valid) e_data = bus_in;
    if (m == 1 && eo[0] == 1'b0) begin
      e_rcv = bus_in[1]; e_se0 = bus_in[2];
    end else if (m == 2) begin
      e_rcv = bus_in[6]; e_dp = bus_in[4]; e_dm = bus_in[5];
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int m_r;
    logic d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state of registered outputs
    check("R10", "reset rx_valid", 32'(rx_valid), 32'h0);
    check("R10", "reset ser regs", {28'b0, ser_rx_rcv, ser_rx_se0, ser_rx_dp, ser_rx_dm}, 32'h0);
    check("R1", "reset drive oe", 32'(bus_oe), 32'hFF);
    check("R1", "reset drive out", 32'(bus_out), 32'h0);
    rst_n = 1'b1;

    // R1 idle, then transmit word
    step(0,0,0,0,8'h00,0,0,0,8'h00);
    step(0,0,0,1,8'hA5,0,0,0,8'h00);
    // R2/R3/R4: directed turnaround, PHY word after turnaround
    step(1,0,0,1,8'hA5,0,0,0,8'h3C);
    step(1,0,0,0,8'h00,0,0,0,8'hC3);
    step(1,0,0,0,8'h00,0,0,0,8'h5A);
    step(0,0,0,1,8'h11,0,0,0,8'hFF);
    step(0,0,0,1,8'h22,0,0,0,8'hFF);
    // single-cycle pulse and immediate re-rise
    step(1,0,0,0,8'h00,0,0,0,8'h77);
    step(0,0,0,0,8'h00,0,0,0,8'h77);
    step(1,0,0,0,8'h00,0,0,0,8'h99);
    step(1,0,0,0,8'h00,0,0,0,8'h66);
    step(0,0,0,0,8'h00,0,0,0,8'h00);
    // R9: both selects
    step(0,1,1,1,8'hF0,1,1,0,8'h00);
    // R5/R6: 3-pin transmit then receive
    step(0,1,0,0,8'h00,1,1,0,8'h00);
    step(0,1,0,0,8'h00,0,0,0,8'h06);
    step(0,1,0,0,8'h00,0,0,0,8'h02);
    // R7/R8: 6-pin
    step(0,0,1,0,8'h00,0,1,1,8'h50);
    step(0,0,1,0,8'h00,1,0,0,8'h20);
    step(1,0,1,0,8'h00,1,0,0,8'h70);
    step(0,0,1,0,8'h00,1,0,0,8'h00);

    d = 1'b0; m_r = 0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 60) == 0) m_r = $urandom % 4;
      if (($urandom % 4) == 0) d = ~d;
      step(d, m_r[0], m_r[1], 1'($urandom), 8'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule